// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block drives a parallel RGB panel from a system clock. A programmable divider produces a pixel-rate enable. Two counters then walk each line and each frame through four regions: active, front porch, sync pulse and back porch. The block drives horizontal and vertical sync at a programmable polarity, a data-enable strobe and a 24-bit colour. During the active area the colour is either a flat background or a test pattern of eight vertical bars, each with its own programmable colour.

Software sets the block up through a write-only register port. Every write lands in a shadow set. A transfer request copies the whole shadow set into the live set that the counters and the output stage use. While the raster runs, the copy is held back until the frame reaches its bottom blanking, so a new mode never tears a visible frame. While the raster is stopped, the copy happens at once. One output flag shows that a request is still waiting.

Top module: `disp_timing_gen`

## Requirements
- R1: After reset, and whenever the live raster-enable bit (bit 14 of the mode word at address 0) is clear, the counters rest at zero, `pix_de` is 0, `rgb` is 0 and both syncs sit at their inactive level.
- R2: The divider word at address 6 holds N in its low DIV_W bits. While the raster runs, the counters advance once every N+1 system clocks.
- R3: A line runs active, then front porch, then sync, then back porch. The active width is 16 times bits [11:0] of the size word at address 2. The horizontal timing word at address 3 holds back porch in [31:22], sync width in [21:11] and front porch in [10:0].
- R4: A frame runs through the same four regions counted in lines. The active height is bits [31:16] of the size word, and the vertical timing word at address 4 uses the same field layout as the horizontal one.
- R5: `pix_de` is 1 only when both the pixel and the line position are inside their active regions.
- R6: In the polarity word at address 5, bit 0 set makes `hsync` active-low and bit 1 set makes `vsync` active-low. A clear bit means active-high.
- R7: The operating field is mode bits [1:0]. In normal mode (value 1), `rgb` carries the 24-bit background word at address 1 during the active area. With values 0 and 2, `rgb` stays 0. Outside the active area, `rgb` is always 0.
- R8: In bar mode (value 3), the active width is split into eight equal bars, each 2×size[11:0] pixels wide. Bar k, counted from the left, shows the colour word at address 8+k.
- R9: Writes to addresses 0 to 6 and 8 to 15 change nothing at the outputs until a transfer is requested.
- R10: Writing a word with bit 30 set to address 7 requests a transfer, and `xfer_pending` rises on the next clock. While the raster runs, all live settings change together at the end of the first pixel of the first front-porch line. At that point `xfer_pending` returns to 0.
- R11: A request made while the live raster is stopped is served on the following clock, so `xfer_pending` is high for exactly one cycle.
- R12: Programmed for a 640-pixel line with front porch 16, sync 96, back porch 48 and divider 0, the line period is 800 clocks, the sync pulse is 96 clocks and `pix_de` is high for 640 clocks per active line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register word address |
| wr_data | input | 32 | Register write data |
| pix_de | output | 1 | Data-enable, high in the active area |
| hsync | output | 1 | Horizontal sync at programmed polarity |
| vsync | output | 1 | Vertical sync at programmed polarity |
| rgb | output | 24 | Pixel colour, red in [23:16], blue in [7:0] |
| xfer_pending | output | 1 | Transfer request not yet served |

## Verification
Some rules hold on every cycle, and the checker asserts them directly:
- a stopped raster stays quiet;
- the colour is zero whenever data-enable is low;
- sync is never active during data-enable;
- the divider count stays within its limit;
- the live set changes only on a transfer event;
- requests set and clear the pending flag as specified.

Other behaviour only shows up over whole lines and frames, so the bench scenarios cover it:
- exact region lengths and their order;
- bar boundaries;
- the frame position at which a deferred transfer lands;
- the 800-clock line of the standard mode.

The bench checks these against a cycle-accurate reference model, using random small configurations as well as directed ones.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int CW    = 16;
  localparam int BAR_N = 8;

  localparam logic [3:0] A_MODE = 4'd0;
  localparam logic [3:0] A_BG   = 4'd1;
  localparam logic [3:0] A_SIZE = 4'd2;
  localparam logic [3:0] A_HTIM = 4'd3;
  localparam logic [3:0] A_VTIM = 4'd4;
  localparam logic [3:0] A_POL  = 4'd5;
  localparam logic [3:0] A_DIV  = 4'd6;
  localparam logic [3:0] A_UPD  = 4'd7;

  typedef enum logic [1:0] {
    OP_OFF = 2'd0, OP_NORMAL = 2'd1, OP_RSV = 2'd2, OP_BARS = 2'd3
  } op_e;

  // field order matches the timing words: back porch high, front porch low
  typedef struct packed {
    logic [9:0]  bp;
    logic [10:0] sw;
    logic [10:0] fp;
  } porch_t;

  typedef struct packed {
    op_e         op;
    logic        en;
    logic [23:0] bg;
    logic [15:0] vact;
    logic [11:0] w16;
    porch_t      h;
    porch_t      v;
    logic        hlow;
    logic        vlow;
    logic [15:0] div;
  } cfg_t;

  function automatic logic [CW-1:0] h_active(logic [11:0] w16);
    return {w16, 4'b0000};
  endfunction

  function automatic logic [12:0] bar_width(logic [11:0] w16);
    return {w16, 1'b0};
  endfunction

  function automatic logic [CW-1:0] sync_begin(logic [CW-1:0] act, porch_t p);
    return act + CW'(p.fp);
  endfunction

  function automatic logic [CW-1:0] sync_end(logic [CW-1:0] act, porch_t p);
    return act + CW'(p.fp) + CW'(p.sw);
  endfunction

  function automatic logic [CW-1:0] span_total(logic [CW-1:0] act, porch_t p);
    return act + CW'(p.fp) + CW'(p.sw) + CW'(p.bp);
  endfunction
endpackage

// File: rtl/dtg_regs.sv
module dtg_regs
  import dtg_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [3:0]              wr_addr,
  input  logic [31:0]             wr_data,
  input  logic                    frame_edge,
  output cfg_t                    live,
  output logic [BAR_N-1:0][23:0]  live_bar,
  output logic                    xfer_req,
  output logic                    xfer_fire,
  output logic                    xfer_pending
);
  cfg_t sh;

  assign xfer_req  = wr_en && (wr_addr == A_UPD) && wr_data[30];
  // a stopped raster has no frame boundary to wait for
  assign xfer_fire = xfer_pending && (!live.en || frame_edge);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh           <= '0;
      live         <= '0;
      xfer_pending <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          A_MODE: begin sh.op <= op_e'(wr_data[1:0]); sh.en <= wr_data[14]; end
          A_BG:   sh.bg <= wr_data[23:0];
          A_SIZE: begin sh.vact <= wr_data[31:16]; sh.w16 <= wr_data[11:0]; end
          A_HTIM: sh.h <= porch_t'(wr_data);
          A_VTIM: sh.v <= porch_t'(wr_data);
          A_POL:  begin sh.hlow <= wr_data[0]; sh.vlow <= wr_data[1]; end
          A_DIV:  sh.div <= 16'(wr_data[DIV_W-1:0]);
          default: ;
        endcase
      end
      if (xfer_fire) live <= sh;
      xfer_pending <= xfer_req || (xfer_pending && !xfer_fire);
    end
  end

  for (genvar b = 0; b < BAR_N; b++) begin : g_bar
    logic [23:0] sh_q, lv_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sh_q <= '0;
        lv_q <= '0;
      end else begin
        if (wr_en && wr_addr[3] && (wr_addr[2:0] == 3'(b))) sh_q <= wr_data[23:0];
        if (xfer_fire) lv_q <= sh_q;
      end
    end
    assign live_bar[b] = lv_q;
  end
endmodule

// File: rtl/dtg_raster.sv
module dtg_raster
  import dtg_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic [15:0]    div_lim,
  input  logic [CW-1:0]  htot,
  input  logic [CW-1:0]  vact,
  input  logic [CW-1:0]  vtot,
  input  logic [12:0]    bar_w,
  output logic           pix_en,
  output logic           frame_edge,
  output logic [15:0]    div_cnt,
  output logic [CW-1:0]  h_cnt,
  output logic [CW-1:0]  v_cnt,
  output logic [2:0]     bar_idx
);
  logic [12:0] bar_pos;
  logic        line_end, frame_end;

  assign pix_en     = run && (div_cnt >= div_lim);
  assign line_end   = h_cnt >= htot - 1'b1;
  assign frame_end  = v_cnt >= vtot - 1'b1;
  assign frame_edge = pix_en && (h_cnt == '0) && (v_cnt == vact);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      div_cnt <= '0;
      h_cnt   <= '0;
      v_cnt   <= '0;
      bar_pos <= '0;
      bar_idx <= '0;
    end else begin
      div_cnt <= pix_en ? '0 : div_cnt + 1'b1;
      if (pix_en) begin
        if (line_end) begin
          h_cnt   <= '0;
          v_cnt   <= frame_end ? '0 : v_cnt + 1'b1;
          bar_pos <= '0;
          bar_idx <= '0;
        end else begin
          h_cnt <= h_cnt + 1'b1;
          if (bar_pos == bar_w - 1'b1) begin
            bar_pos <= '0;
            bar_idx <= bar_idx + 1'b1;
          end else begin
            bar_pos <= bar_pos + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dtg_pixel.sv
module dtg_pixel
  import dtg_pkg::*;
(
  input  logic                   run,
  input  op_e                    op,
  input  logic [23:0]            bg,
  input  logic [BAR_N-1:0][23:0] bars,
  input  logic                   hlow,
  input  logic                   vlow,
  input  logic [CW-1:0]          h_cnt,
  input  logic [CW-1:0]          v_cnt,
  input  logic [CW-1:0]          hact,
  input  logic [CW-1:0]          vact,
  input  logic [CW-1:0]          hs_beg,
  input  logic [CW-1:0]          hs_end,
  input  logic [CW-1:0]          vs_beg,
  input  logic [CW-1:0]          vs_end,
  input  logic [2:0]             bar_idx,
  output logic                   de,
  output logic                   hsync,
  output logic                   vsync,
  output logic [23:0]            rgb
);
  logic hs_act, vs_act;

  assign de     = run && (h_cnt < hact) && (v_cnt < vact);
  assign hs_act = run && (h_cnt >= hs_beg) && (h_cnt < hs_end);
  assign vs_act = run && (v_cnt >= vs_beg) && (v_cnt < vs_end);
  assign hsync  = hs_act ^ hlow;
  assign vsync  = vs_act ^ vlow;

  always_comb begin
    rgb = '0;
    if (de) begin
      case (op)
        OP_NORMAL: rgb = bg;
        OP_BARS:   rgb = bars[bar_idx];
        default:   rgb = '0;
      endcase
    end
  end
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import dtg_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wr_addr,
  input  logic [31:0] wr_data,
  output logic        pix_de,
  output logic        hsync,
  output logic        vsync,
  output logic [23:0] rgb,
  output logic        xfer_pending
);
  localparam int FLAT_W = $bits(cfg_t) + BAR_N * 24;

  cfg_t                   live;
  logic [BAR_N-1:0][23:0] live_bar;
  logic                   xfer_req, xfer_fire, frame_edge, pix_en;
  logic [15:0]            div_cnt;
  logic [CW-1:0]          h_cnt, v_cnt, hact, vact, htot, vtot;
  logic [2:0]             bar_idx;
  logic                   live_run;
  logic [FLAT_W-1:0]      live_flat;

  assign live_run  = live.en;
  assign live_flat = {live, live_bar};
  assign hact      = h_active(live.w16);
  assign vact      = live.vact;
  assign htot      = span_total(hact, live.h);
  assign vtot      = span_total(vact, live.v);

  dtg_regs #(.DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_edge(frame_edge), .live(live), .live_bar(live_bar),
    .xfer_req(xfer_req), .xfer_fire(xfer_fire), .xfer_pending(xfer_pending)
  );

  dtg_raster u_raster (
    .clk(clk), .rst_n(rst_n), .run(live_run), .div_lim(live.div),
    .htot(htot), .vact(vact), .vtot(vtot), .bar_w(bar_width(live.w16)),
    .pix_en(pix_en), .frame_edge(frame_edge), .div_cnt(div_cnt),
    .h_cnt(h_cnt), .v_cnt(v_cnt), .bar_idx(bar_idx)
  );

  dtg_pixel u_pixel (
    .run(live_run), .op(live.op), .bg(live.bg), .bars(live_bar),
    .hlow(live.hlow), .vlow(live.vlow), .h_cnt(h_cnt), .v_cnt(v_cnt),
    .hact(hact), .vact(vact),
    .hs_beg(sync_begin(hact, live.h)), .hs_end(sync_end(hact, live.h)),
    .vs_beg(sync_begin(vact, live.v)), .vs_end(sync_end(vact, live.v)),
    .bar_idx(bar_idx), .de(pix_de), .hsync(hsync), .vsync(vsync), .rgb(rgb)
  );
endmodule

// File: rtl/dtg_checker.sv
module dtg_checker #(
  parameter int FLAT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              hlow,
  input logic              vlow,
  input logic              de,
  input logic              hsync,
  input logic              vsync,
  input logic [23:0]       rgb,
  input logic [15:0]       div_cnt,
  input logic [15:0]       div_lim,
  input logic              xfer_req,
  input logic              xfer_fire,
  input logic              xfer_pending,
  input logic [FLAT_W-1:0] live_flat
);
  assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!de && rgb == 24'd0 && hsync == hlow && vsync == vlow));

  assert_div_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> div_cnt <= div_lim);

  assert_de_no_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (hsync == hlow && vsync == vlow));

  assert_blank_black_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !de |-> rgb == 24'd0);

  assert_live_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_fire |=> $stable(live_flat));

  assert_req_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |=> xfer_pending);

  assert_fire_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_fire && !xfer_req) |=> !xfer_pending);

  assert_stopped_fast_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_pending && !run) |-> xfer_fire);
endmodule

bind disp_timing_gen dtg_checker #(.FLAT_W(FLAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(live_run), .hlow(live.hlow), .vlow(live.vlow),
  .de(pix_de), .hsync(hsync), .vsync(vsync), .rgb(rgb),
  .div_cnt(div_cnt), .div_lim(live.div), .xfer_req(xfer_req),
  .xfer_fire(xfer_fire), .xfer_pending(xfer_pending), .live_flat(live_flat)
);

// File: tb/tb_disp_timing_gen.sv
module tb_disp_timing_gen;
  localparam int PERIOD = 10;
  localparam int DIV_W  = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        pix_de, hsync, vsync, xfer_pending;
  logic [23:0] rgb;

  int checks = 0;
  int bad = 0;
  bit cmp_on = 0;
  string cur_req = "R1";

  always #(PERIOD/2) clk = ~clk;

  disp_timing_gen #(.DIV_W(DIV_W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pix_de(pix_de), .hsync(hsync), .vsync(vsync), .rgb(rgb), .xfer_pending(xfer_pending)
  );

  // ---------------- reference model, built from the requirements ----------
  logic [31:0] s_reg [16];
  logic [31:0] l_reg [16];
  bit          m_pend;
  int unsigned m_div, m_h, m_v;

  function automatic int unsigned f_hact(logic [31:0] sz); return (sz & 32'hfff) * 16; endfunction
  function automatic int unsigned f_vact(logic [31:0] sz); return sz >> 16; endfunction
  function automatic int unsigned f_fp(logic [31:0] t); return t & 32'h7ff; endfunction
  function automatic int unsigned f_sw(logic [31:0] t); return (t >> 11) & 32'h7ff; endfunction
  function automatic int unsigned f_bp(logic [31:0] t); return t >> 22; endfunction
  function automatic logic [31:0] tword(int unsigned bp, int unsigned sw, int unsigned fp);
    return (bp << 22) | (sw << 11) | fp;
  endfunction

  int unsigned hact, vact, htot, vtot, ldiv;
  bit lrun, pixen, fire, req;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin s_reg[i] = '0; l_reg[i] = '0; end
      m_pend = 0; m_div = 0; m_h = 0; m_v = 0;
    end else begin
      lrun  = l_reg[0][14];
      ldiv  = l_reg[6] & ((1 << DIV_W) - 1);
      hact  = f_hact(l_reg[2]);
      vact  = f_vact(l_reg[2]);
      htot  = hact + f_fp(l_reg[3]) + f_sw(l_reg[3]) + f_bp(l_reg[3]);
      vtot  = vact + f_fp(l_reg[4]) + f_sw(l_reg[4]) + f_bp(l_reg[4]);
      pixen = lrun && (m_div >= ldiv);
      fire  = m_pend && (!lrun || (pixen && m_h == 0 && m_v == vact));
      req   = wr_en && wr_addr == 4'd7 && wr_data[30];
      if (!lrun) begin
        m_div = 0; m_h = 0; m_v = 0;
      end else begin
        m_div = pixen ? 0 : m_div + 1;
        if (pixen) begin
          if (m_h + 1 >= htot) begin
            m_h = 0;
            m_v = (m_v + 1 >= vtot) ? 0 : m_v + 1;
          end else m_h = m_h + 1;
        end
      end
      if (fire) for (int i = 0; i < 16; i++) l_reg[i] = s_reg[i];
      if (wr_en) s_reg[wr_addr] = wr_data;
      m_pend = req || (m_pend && !fire);
    end
  end

  logic        e_de, e_hs, e_vs;
  logic [23:0] e_rgb;
  int unsigned hb, vb, bw;
  always @(negedge clk) begin
    if (cmp_on) begin
      lrun = l_reg[0][14];
      hact = f_hact(l_reg[2]);
      vact = f_vact(l_reg[2]);
      hb   = hact + f_fp(l_reg[3]);
      vb   = vact + f_fp(l_reg[4]);
      e_de = lrun && m_h < hact && m_v < vact;
      e_hs = (lrun && m_h >= hb && m_h < hb + f_sw(l_reg[3])) ^ l_reg[5][0];
      e_vs = (lrun && m_v >= vb && m_v < vb + f_sw(l_reg[4])) ^ l_reg[5][1];
      e_rgb = '0;
      if (e_de && l_reg[0][1:0] == 2'd1) e_rgb = l_reg[1][23:0];
      if (e_de && l_reg[0][1:0] == 2'd3) begin
        bw = 2 * (l_reg[2] & 32'hfff);
        e_rgb = l_reg[8 + m_h / bw][23:0];
      end
      checks++;
      if (pix_de !== e_de || hsync !== e_hs || vsync !== e_vs || rgb !== e_rgb ||
          xfer_pending !== m_pend) begin
        bad++;
        $display("FAIL %s model: de/hs/vs/rgb/pend actual=%0b%0b%0b %h %0b expected=%0b%0b%0b %h %0b",
                 cur_req, pix_de, hsync, vsync, rgb, xfer_pending,
                 e_de, e_hs, e_vs, e_rgb, m_pend);
      end
    end
  end

  // ---------------- helpers -----------------------------------------------
  task automatic chk(string r, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_pend_clear();
    for (int i = 0; i < 40000 && xfer_pending; i++) @(negedge clk);
  endtask

  // measure one hsync period and pulse width (active level act_lvl)
  task automatic measure_h(logic act_lvl, output int pulse, output int period);
    logic prev;
    prev = hsync;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (prev != act_lvl && hsync == act_lvl) break;
      prev = hsync;
    end
    pulse = 0;
    while (hsync == act_lvl && pulse < 20000) begin pulse++; @(negedge clk); end
    period = pulse;
    prev = hsync;
    for (int i = 0; i < 20000; i++) begin
      period++;
      @(negedge clk);
      if (prev != act_lvl && hsync == act_lvl) break;
      prev = hsync;
    end
  endtask

  task automatic main();
    int pulse, period, hi, cnt;
    logic [31:0] w16, vl;
    void'($urandom(32'h5eed_0042));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "de", pix_de, 0);
    chk("R1", "rgb", rgb, 0);
    chk("R1", "hsync", hsync, 0);
    chk("R1", "vsync", vsync, 0);
    chk("R1", "pending", xfer_pending, 0);
    cmp_on = 1;

    // R9: shadow writes alone leave outputs quiet
    cur_req = "R9";
    wr(4'd0, 32'h4001);
    wr(4'd1, 32'h00a1b2c3);
    wr(4'd2, (32'd4 << 16) | 32'd2);
    wr(4'd3, tword(3, 2, 2));
    wr(4'd4, tword(1, 1, 1));
    wr(4'd6, 32'd0);
    hi = 0;
    repeat (40) begin @(negedge clk); if (pix_de) hi++; end
    chk("R9", "de cycles before transfer", hi, 0);

    // R11: transfer while stopped is served next clock
    cur_req = "R11";
    wr(4'd7, 32'h4000_0000);
    chk("R11", "pending after request", xfer_pending, 1);
    @(negedge clk);
    chk("R11", "pending one cycle later", xfer_pending, 0);

    // R10: transfer while running waits for the front porch
    cur_req = "R10";
    repeat (5) @(negedge clk);
    wr(4'd1, 32'h00ff0011);
    wr(4'd7, 32'h4000_0000);
    cnt = 0;
    while (xfer_pending && cnt < 40000) begin cnt++; @(negedge clk); end
    chk("R10", "deferred (>3 cycles pending)", cnt > 3, 1);
    chk("R10", "pending cleared", xfer_pending, 0);

    // R2: divider
    cur_req = "R2";
    wr(4'd0, 32'h4001);
    wr(4'd2, (32'd3 << 16) | 32'd2);
    wr(4'd3, tword(4, 3, 2));
    wr(4'd5, 32'd0);
    wr(4'd6, 32'd3);
    wr(4'd7, 32'h4000_0000);
    wait_pend_clear();
    measure_h(1'b1, pulse, period);
    chk("R2", "hsync pulse clocks", pulse, 12);
    chk("R2", "line period clocks", period, 164);

    // random configurations: R3 R4 R5 R6 R7 R8
    for (int r = 0; r < 7; r++) begin
      cur_req = "R3/R4/R5/R6/R7/R8";
      w16 = 1 + $urandom_range(0, 2);
      vl  = 1 + $urandom_range(0, 4);
      wr(4'd0, 32'h4000 | ((r % 4 == 0) ? 32'd1 : (r % 4 == 1) ? 32'd3 :
                           (r % 4 == 2) ? 32'd2 : 32'd3));
      wr(4'd1, $urandom & 32'hffffff);
      wr(4'd2, (vl << 16) | w16);
      wr(4'd3, tword($urandom_range(1, 5), $urandom_range(1, 5), $urandom_range(1, 5)));
      wr(4'd4, tword($urandom_range(1, 4), $urandom_range(1, 3), $urandom_range(1, 4)));
      wr(4'd5, $urandom_range(0, 3));
      wr(4'd6, $urandom_range(0, 3));
      for (int b = 0; b < 8; b++) wr(4'(8 + b), $urandom & 32'hffffff);
      wr(4'd7, 32'h4000_0000);
      wait_pend_clear();
      repeat (6000) @(negedge clk);
    end

    // R12: standard 640-wide line, active-low syncs
    cur_req = "R12";
    wr(4'd0, 32'h4001);
    wr(4'd2, (32'd480 << 16) | 32'd40);
    wr(4'd3, tword(48, 96, 16));
    wr(4'd4, tword(33, 2, 10));
    wr(4'd5, 32'd3);
    wr(4'd6, 32'd0);
    wr(4'd7, 32'h4000_0000);
    wait_pend_clear();
    measure_h(1'b0, pulse, period);
    chk("R12", "hsync pulse clocks", pulse, 96);
    chk("R12", "line period clocks", period, 800);
    for (int i = 0; i < 60000 && !pix_de; i++) @(negedge clk);
    hi = 0;
    while (pix_de && hi < 2000) begin hi++; @(negedge clk); end
    chk("R12", "de clocks per line", hi, 640);
  endtask

  initial begin
    fork
      main();
      begin
        #(PERIOD * 195000);
        bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    cmp_on = 0;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule